// File: doc/BRIEF.md
# Cascadable Fall-Through FIFO

This block is a first-in first-out store of 16 words of 4 bits each. It is built as a chain of stage registers, and every stage has its own occupancy flag. A word written at the input stage moves one stage per clock toward the output stage, as long as the stage ahead of it is free. When a word leaves the output stage, the free slot moves back toward the input in the same way, one stage per clock.

The input side has a shift-in request and an input-ready flag. The output side has a shift-out request and an output-ready flag. The handshake lets two identical instances connect with no extra logic:

- the upstream output-ready drives the downstream shift-in;
- the upstream data output drives the downstream data input;
- the downstream input-ready drives the upstream shift-out.

Two instances joined this way form a 32-word FIFO.

Top module: `ft_fifo`

## Requirements
- R1: A single instance holds DEPTH (16) words of WIDTH (4) bits. With DEPTH words stored and none removed, `in_ready` is low.
- R2: While the synchronous active-high `rst` is sampled high, all stages are emptied. After reset, `in_ready` is 1, `out_ready` is 0 and `dout` is 0.
- R3: A word accepted into an empty instance raises `out_ready` DEPTH-1 clocks after its accepting edge. Through a two-instance cascade, the delay is 2*DEPTH-1 clocks.
- R4: Words leave in the order they were accepted, with no word lost or duplicated. This includes words that cross the boundary between cascaded instances.
- R5: `shift_in` is accepted only at an edge where `in_ready` is high. At any other edge it is ignored and stores nothing.
- R6: `shift_out` is accepted only at an edge where `out_ready` is high. At any other edge it is ignored and removes nothing.
- R7: In the cycle after an accepted shift-in, `in_ready` is low, because the word needs one clock to advance out of the input stage.
- R8: In the cycle after an accepted shift-out, `out_ready` is low. While `shift_out` is held high, each arriving word raises `out_ready` for one cycle only and is consumed.
- R9: While `out_ready` is high and `shift_out` is low, `out_ready` stays high and `dout` stays unchanged.
- R10: After one word is removed from a full instance, `in_ready` rises DEPTH-1 clocks after the removing edge. In a full two-instance cascade, the upstream `in_ready` rises 2*DEPTH-1 clocks after the removing edge. During that time the downstream `in_ready` is high for exactly one cycle, so exactly one word crosses the boundary.
- R11: Connecting `out_ready` to the next `shift_in`, `dout` to the next `din`, and the next `in_ready` to `shift_out` forms a 2*DEPTH-word FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_in | input | 1 | Request to store `din` |
| din | input | WIDTH | Word to store |
| in_ready | output | 1 | Input stage is free |
| shift_out | input | 1 | Request to remove the output word |
| out_ready | output | 1 | Output stage holds a word |
| dout | output | WIDTH | Word in the output stage |

## Verification
The bound checker is evaluated on every clock. It checks that:
- an accepted push or pop is followed by a low ready flag (R7, R8);
- an output word is held until it is taken (R9);
- a running occupancy count keeps the ready flags consistent with full and empty (R1, R6).

Some behaviour can only be shown by the bench's cascade scenarios. These are the exact ripple-through and bubble-up latencies, the single boundary crossing after a pop from a full cascade, and the ordering of 32 words through fill and drain with ignored requests mixed in.

// File: rtl/ft_fifo_pkg.sv
package ft_fifo_pkg;
  localparam int FT_WIDTH = 4;
  localparam int FT_DEPTH = 16;

  // Stage moves for one clock: a word arrives, a word departs, or neither.
  typedef struct packed {
    logic arrive;
    logic depart;
  } ft_move_t;
endpackage

// File: rtl/ft_fifo_stage.sv
module ft_fifo_stage
  import ft_fifo_pkg::*;
#(
  parameter int WIDTH = FT_WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  ft_move_t         move,
  input  logic [WIDTH-1:0] d_in,
  output logic             full,
  output logic [WIDTH-1:0] d_out
);
  // Arrive and depart are mutually exclusive: an arrival needs an empty stage,
  // and a departure needs a full one.
  always_ff @(posedge clk) begin
    if (rst) begin
      full  <= 1'b0;
      d_out <= '0;
    end else if (move.arrive) begin
      full  <= 1'b1;
      d_out <= d_in;
    end else if (move.depart) begin
      full  <= 1'b0;
    end
  end
endmodule

// File: rtl/ft_fifo_in_port.sv
module ft_fifo_in_port (
  input  logic shift_in,
  input  logic head_full,
  output logic push,
  output logic in_ready
);
  assign in_ready = ~head_full;
  assign push     = shift_in & ~head_full;
endmodule

// File: rtl/ft_fifo_out_port.sv
module ft_fifo_out_port #(
  parameter int WIDTH = 4
) (
  input  logic             shift_out,
  input  logic             tail_full,
  input  logic [WIDTH-1:0] tail_data,
  output logic             pop,
  output logic             out_ready,
  output logic [WIDTH-1:0] dout
);
  assign out_ready = tail_full;
  assign pop       = shift_out & tail_full;
  assign dout      = tail_data;
endmodule

// File: rtl/ft_fifo.sv
module ft_fifo
  import ft_fifo_pkg::*;
#(
  parameter int WIDTH = FT_WIDTH,
  parameter int DEPTH = FT_DEPTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_in,
  input  logic [WIDTH-1:0] din,
  output logic             in_ready,
  input  logic             shift_out,
  output logic             out_ready,
  output logic [WIDTH-1:0] dout
);
  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0] sfull;
  logic [WIDTH-1:0] sdata [DEPTH];
  logic [LAST-1:0]  adv;
  ft_move_t         smove [DEPTH];
  logic             push;
  logic             pop;

  ft_fifo_in_port u_in (
    .shift_in (shift_in),
    .head_full(sfull[0]),
    .push     (push),
    .in_ready (in_ready)
  );

  ft_fifo_out_port #(.WIDTH(WIDTH)) u_out (
    .shift_out(shift_out),
    .tail_full(sfull[LAST]),
    .tail_data(sdata[LAST]),
    .pop      (pop),
    .out_ready(out_ready),
    .dout     (dout)
  );

  // A word advances when its stage is full and the next stage is empty,
  // judged on this cycle's flags, so it moves at most one stage per clock.
  for (genvar i = 0; i < LAST; i++) begin : g_adv
    assign adv[i] = sfull[i] & ~sfull[i+1];
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic [WIDTH-1:0] feed;

    if (i == 0) begin : g_head
      assign smove[i].arrive = push;
      assign feed            = din;
    end else begin : g_body
      assign smove[i].arrive = adv[i-1];
      assign feed            = sdata[i-1];
    end

    if (i == LAST) begin : g_tail
      assign smove[i].depart = pop;
    end else begin : g_mid
      assign smove[i].depart = adv[i];
    end

    ft_fifo_stage #(.WIDTH(WIDTH)) u_stage (
      .clk  (clk),
      .rst  (rst),
      .move (smove[i]),
      .d_in (feed),
      .full (sfull[i]),
      .d_out(sdata[i])
    );
  end
endmodule

// File: rtl/ft_fifo_chk.sv
module ft_fifo_chk #(
  parameter int WIDTH = 4,
  parameter int DEPTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             shift_in,
  input logic             in_ready,
  input logic             shift_out,
  input logic             out_ready,
  input logic [WIDTH-1:0] dout
);
  localparam int CW = $clog2(DEPTH + 1) + 1;

  logic [CW-1:0] occ;
  logic          acc_in;
  logic          acc_out;

  assign acc_in  = shift_in & in_ready;
  assign acc_out = shift_out & out_ready;

  // Running count of stored words, built from the port handshakes only.
  always_ff @(posedge clk) begin
    if (rst) begin
      occ <= '0;
    end else begin
      case ({acc_in, acc_out})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  // R7
  push_gap_chk: assert property (@(posedge clk) disable iff (rst)
    acc_in |=> !in_ready);

  // R8
  pop_gap_chk: assert property (@(posedge clk) disable iff (rst)
    acc_out |=> !out_ready);

  // R9
  hold_out_chk: assert property (@(posedge clk) disable iff (rst)
    (out_ready && !shift_out) |=> (out_ready && $stable(dout)));

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (occ >= CW'(DEPTH)) |-> !in_ready);

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (occ == '0) |-> !out_ready);
endmodule

bind ft_fifo ft_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .shift_in (shift_in),
  .in_ready (in_ready),
  .shift_out(shift_out),
  .out_ready(out_ready),
  .dout     (dout)
);

// File: tb/ft_fifo_test.sv
`timescale 1ns/1ps
module ft_fifo_test;
  localparam int W = 4;
  localparam int D = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic s_in = 1'b0;
  logic [W-1:0] d_in = '0;
  logic s_out = 1'b0;
  logic a_ir, a_or, b_ir, b_or;
  logic [W-1:0] a_do, b_do;

  int checks = 0;
  int errors = 0;
  int pushed = 0;
  int popped = 0;
  logic [W-1:0] q[$];
  bit prev_push = 0;
  bit prev_pop = 0;

  always #2.5 clk = ~clk;

  // R11: two instances joined directly, with no glue logic.
  ft_fifo #(.WIDTH(W), .DEPTH(D)) uut (
    .clk(clk), .rst(rst), .shift_in(s_in), .din(d_in), .in_ready(a_ir),
    .shift_out(b_ir), .out_ready(a_or), .dout(a_do)
  );
  ft_fifo #(.WIDTH(W), .DEPTH(D)) uut2 (
    .clk(clk), .rst(rst), .shift_in(a_or), .din(a_do), .in_ready(b_ir),
    .shift_out(s_out), .out_ready(b_or), .dout(b_do)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Reference model: a queue of accepted words, compared on every clock.
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_push) chk(!a_ir, "R7", a_ir, 0);
      if (prev_pop)  chk(!b_or, "R8", b_or, 0);
      if (b_or)      chk(q.size() > 0, "R6", q.size(), 1);
      if (q.size() == 2*D) chk(!a_ir, "R1", a_ir, 0);
      if (a_ir)      chk(q.size() < 2*D, "R1", q.size(), 2*D-1);
      prev_push = s_in && a_ir;
      prev_pop  = s_out && b_or;
      if (prev_pop) begin
        chk(q.size() > 0 && b_do == q[0], "R4", b_do, q.size() > 0 ? q[0] : 0);
        if (q.size() > 0) void'(q.pop_front());
        popped++;
      end
      if (prev_push) begin
        q.push_back(d_in);
        pushed++;
      end
    end
  end

  task automatic push_word(input logic [W-1:0] v);
    @(posedge clk); #1;
    s_in = 1'b1; d_in = v;
    @(negedge clk);
    while (!a_ir) @(negedge clk);
    @(posedge clk); #1;
    s_in = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, na, hits, p0;
    logic [W-1:0] held;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R2
    chk(a_ir == 1'b1, "R2", a_ir, 1);
    chk(b_or == 1'b0 && a_or == 1'b0, "R2", b_or, 0);
    chk(b_do == '0, "R2", b_do, 0);

    // R3: ripple-through latency for one instance and for the cascade.
    @(posedge clk); #1;
    s_in = 1'b1; d_in = 4'h9;
    @(posedge clk); #1;
    s_in = 1'b0;
    n = 0; na = -1;
    @(negedge clk);
    while (!b_or && n < 100) begin
      if (a_or && na < 0) na = n;
      @(negedge clk);
      n++;
    end
    chk(na == D-1, "R3", na, D-1);
    chk(n == 2*D-1, "R3", n, 2*D-1);

    // R9: the word is held while nobody takes it.
    held = b_do;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(b_or && b_do == held, "R9", b_do, held);
    end
    @(posedge clk); #1 s_out = 1'b1;
    @(posedge clk); #1 s_out = 1'b0;

    // R6: a shift-out while empty removes nothing.
    @(posedge clk); #1 s_out = 1'b1;
    for (int k = 0; k < 8; k++) @(negedge clk);
    p0 = popped;
    chk(p0 == 1 && !b_or, "R6", p0, 1);

    // R8: with shift-out held, out_ready pulses once and the word is taken.
    push_word(4'h5);
    hits = 0;
    for (int k = 0; k < 45; k++) begin
      @(negedge clk);
      if (b_or) hits++;
    end
    chk(hits == 1, "R8", hits, 1);
    chk(popped == 2 && q.size() == 0, "R8", popped, 2);
    @(posedge clk); #1 s_out = 1'b0;

    // R11 / R1: fill the cascade with 32 words.
    for (int i = 0; i < 2*D; i++) push_word(W'((i*7 + 3) % 16));
    repeat (80) @(negedge clk);
    chk(!a_ir && a_or && b_or, "R1", {a_ir, a_or, b_or}, 3);
    chk(q.size() == 2*D, "R11", q.size(), 2*D);

    // R5: shift-in while full is ignored.
    p0 = pushed;
    @(posedge clk); #1 s_in = 1'b1; d_in = 4'hE;
    repeat (20) @(negedge clk);
    @(posedge clk); #1 s_in = 1'b0;
    @(negedge clk);
    chk(pushed == p0, "R5", pushed, p0);

    // R10: bubble-up after one pop from the full cascade.
    @(posedge clk); #1 s_out = 1'b1;
    @(posedge clk); #1 s_out = 1'b0;
    n = 0; hits = 0;
    @(negedge clk);
    while (!a_ir && n < 100) begin
      if (b_ir) hits++;
      @(negedge clk);
      n++;
    end
    chk(n == 2*D-1, "R10", n, 2*D-1);
    chk(hits == 1, "R10", hits, 1);

    // R4: refill one word, then drain everything in order.
    push_word(4'hA);
    @(posedge clk); #1 s_out = 1'b1;
    n = 0;
    while ((q.size() > 0 || b_or) && n < 2000) begin
      @(negedge clk);
      n++;
    end
    repeat (40) @(negedge clk);
    chk(popped == pushed && q.size() == 0, "R4", popped, pushed);
    chk(!b_or && a_ir, "R4", b_or, 0);
    s_out = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule